// File: doc/BRIEF.md
# Fractional Clock-Enable Scaler with Deferred Commit

This block turns a free-running clock into one or two clock-enable strobes. The fast strobe is high on `m` of every 32 input cycles, where `m` runs from 1 to 32, and its pulses are spread as evenly as the step size allows. A second strobe divides the fast strobe by a fixed parameter `POST_DIV`. The rate of the slow strobe is therefore the input rate times m / (32 · POST_DIV).

Software writes a 5-bit step field in a rate register. The field holds 32 minus the wanted multiplier, so a field of 0 gives full rate. The new value does nothing until software sets a commit flag, which is written through a separate register strobe. The block waits for the end of the current 32-cycle frame before it loads the new multiplier and restarts the spreading phase and the post-divider. In that same cycle it clears the commit flag. While the flag still reads 1, software treats the divider as busy.

Top module: `frac_clk_scaler`

## Requirements
- R1: After reset, `kick_busy` is 0, `rate_rdata` is 0 and the active multiplier is 32, so `fast_en` is 1 on every cycle.
- R2: A cycle with `rate_wr`=1 stores the whole `rate_wdata` word, which reads back on `rate_rdata` from the next cycle. The step field sits at bits [FIELD_LSB+4:FIELD_LSB]; the default is bits [12:8].
- R3: Writing the rate register without a commit leaves the `fast_en`/`slow_en` cadence unchanged. The active multiplier changes only at a frame boundary.
- R4: A cycle with `kick_wr`=1 and `kick_wbit`=1 sets `kick_busy` from the next cycle on. With `kick_wbit`=0 the write has no effect.
- R5: `kick_busy` stays 1 until the last cycle of a 32-cycle frame. In the cycle after that, the new setting is active and `kick_busy` reads 0. A commit written during a frame's last cycle waits for the whole following frame, which gives 32 busy cycles. A commit written one cycle earlier gives 1 busy cycle.
- R6: The active multiplier is m = 32 − field. In each 32-cycle frame, `fast_en` is high on exactly m cycles.
- R7: Counting frame positions i = 0..31 from the first cycle after a load, `fast_en` is high at position i exactly when floor((i+1)·m/32) > floor(i·m/32).
- R8: A field of 0 gives pass-through: `fast_en` is high on every cycle.
- R9: `slow_en` is high only together with `fast_en`, on every POST_DIV-th fast pulse (default 3) counted from the load. The post-divider count restarts at each load.
- R10: `kick_busy` never stays high for more than 32 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rate_wr | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 32 | Rate register write word |
| kick_wr | input | 1 | Write strobe for the commit register |
| kick_wbit | input | 1 | Commit bit value carried by the commit write |
| rate_rdata | output | 32 | Rate register contents |
| kick_busy | output | 1 | Commit pending (busy) |
| fast_en | output | 1 | Clock enable at the rate m/32 |
| slow_en | output | 1 | Clock enable at the rate m/(32·POST_DIV) |

## Verification
Every one of the 32 field values is committed in turn, each with unrelated bits set around the field. For each value, one frame of `fast_en` is compared position by position against the floor-based spreading formula. This separates a wrong multiplier encoding, a wrong field offset and uneven or bunched pulses. The same frames also check the post-divided strobe against a pulse ordinal that restarts at each load. Timing tests place a commit on the last and on the second-to-last cycle of a frame, which shows whether the load waits for the frame boundary. A rate write without a commit and a commit write with its bit clear must both leave the cadence exactly as before.

// File: rtl/frac_clk_scaler_pkg.sv
package frac_clk_scaler_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [0:0] {
    COMMIT_IDLE    = 1'b0,
    COMMIT_PENDING = 1'b1
  } commit_state_e;
endpackage

// File: rtl/frac_clk_scaler_commit.sv
module frac_clk_scaler_commit
  import frac_clk_scaler_pkg::*;
#(
  parameter int unsigned STEP_W    = 5,
  parameter int unsigned FIELD_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [REG_W-1:0]  rate_wdata,
  input  logic              kick_wr,
  input  logic              kick_wbit,
  output logic [REG_W-1:0]  rate_q,
  output logic              busy,
  output logic              load,
  output logic [STEP_W-1:0] frm_cnt,
  output logic [STEP_W:0]   act_mult
);
  localparam int unsigned STEPS = 1 << STEP_W;
  localparam logic [STEP_W-1:0] LAST_POS = STEP_W'(STEPS - 1);
  localparam logic [STEP_W:0]   FULL     = (STEP_W+1)'(STEPS);

  commit_state_e       st_q, st_d;
  logic [REG_W-1:0]    rate_d;
  logic [STEP_W-1:0]   frm_d;
  logic [STEP_W:0]     mult_d;
  logic [STEP_W-1:0]   field;
  logic                frame_last;

  assign field      = rate_q[FIELD_LSB +: STEP_W];
  assign frame_last = (frm_cnt == LAST_POS);
  assign load       = (st_q == COMMIT_PENDING) && frame_last;
  assign busy       = (st_q == COMMIT_PENDING);

  always_comb begin
    rate_d = rate_q;
    if (rate_wr) rate_d = rate_wdata;

    st_d = st_q;
    unique case (st_q)
      COMMIT_IDLE:    if (kick_wr && kick_wbit) st_d = COMMIT_PENDING;
      COMMIT_PENDING: if (frame_last)           st_d = COMMIT_IDLE;
      default:                                  st_d = COMMIT_IDLE;
    endcase

    frm_d = frm_cnt + 1'b1;

    mult_d = act_mult;
    if (load) mult_d = FULL - {1'b0, field};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q   <= '0;
      st_q     <= COMMIT_IDLE;
      frm_cnt  <= '0;
      act_mult <= FULL;
    end else begin
      rate_q   <= rate_d;
      st_q     <= st_d;
      frm_cnt  <= frm_d;
      act_mult <= mult_d;
    end
  end
endmodule

// File: rtl/frac_clk_scaler_accum.sv
module frac_clk_scaler_accum #(
  parameter int unsigned STEP_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [STEP_W:0] mult,
  output logic            pulse
);
  logic [STEP_W-1:0] acc_q, acc_d;
  logic [STEP_W:0]   sum;

  assign sum   = {1'b0, acc_q} + mult;
  assign pulse = sum[STEP_W];

  always_comb begin
    acc_d = sum[STEP_W-1:0];
    if (load) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_clk_scaler_postdiv.sv
module frac_clk_scaler_postdiv #(
  parameter int unsigned POST_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en_in,
  output logic en_out
);
  generate
    if (POST_DIV <= 1) begin : g_bypass
      assign en_out = en_in;
    end else begin : g_count
      localparam int unsigned DIV_W = $clog2(POST_DIV);
      localparam logic [DIV_W-1:0] TOP = DIV_W'(POST_DIV - 1);
      logic [DIV_W-1:0] cnt_q, cnt_d;
      logic             at_top;

      assign at_top = (cnt_q == TOP);
      assign en_out = en_in && at_top;

      always_comb begin
        cnt_d = cnt_q;
        if (en_in) cnt_d = at_top ? '0 : cnt_q + 1'b1;
        if (load)  cnt_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/frac_clk_scaler.sv
module frac_clk_scaler
  import frac_clk_scaler_pkg::*;
#(
  parameter int unsigned STEP_W    = 5,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned POST_DIV  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [REG_W-1:0]  rate_wdata,
  input  logic              kick_wr,
  input  logic              kick_wbit,
  output logic [REG_W-1:0]  rate_rdata,
  output logic              kick_busy,
  output logic              fast_en,
  output logic              slow_en
);
  logic              rst_meta, rst_ns;
  logic              load;
  logic [STEP_W-1:0] frm_cnt;
  logic [STEP_W:0]   act_mult;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  frac_clk_scaler_commit #(.STEP_W(STEP_W), .FIELD_LSB(FIELD_LSB)) u_commit (
    .clk(clk), .rst_n(rst_ns),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .kick_wr(kick_wr), .kick_wbit(kick_wbit),
    .rate_q(rate_rdata), .busy(kick_busy), .load(load),
    .frm_cnt(frm_cnt), .act_mult(act_mult)
  );

  frac_clk_scaler_accum #(.STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_ns), .load(load), .mult(act_mult), .pulse(fast_en)
  );

  frac_clk_scaler_postdiv #(.POST_DIV(POST_DIV)) u_post (
    .clk(clk), .rst_n(rst_ns), .load(load), .en_in(fast_en), .en_out(slow_en)
  );
endmodule

// File: rtl/frac_clk_scaler_chk.sv
module frac_clk_scaler_chk #(
  parameter int unsigned STEP_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick_wr,
  input logic              kick_wbit,
  input logic              kick_busy,
  input logic              fast_en,
  input logic              slow_en,
  input logic [STEP_W-1:0] frm_cnt,
  input logic [STEP_W:0]   act_mult
);
  localparam int unsigned STEPS = 1 << STEP_W;
  localparam logic [STEP_W-1:0] LAST_POS = STEP_W'(STEPS - 1);

  logic [STEP_W:0] fcnt_q;
  logic [STEP_W:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      age_q  <= '0;
    end else begin
      if (frm_cnt == LAST_POS) fcnt_q <= '0;
      else                     fcnt_q <= fcnt_q + {{STEP_W{1'b0}}, fast_en};
      if (kick_busy) age_q <= (age_q == '1) ? age_q : age_q + 1'b1;
      else           age_q <= '0;
    end
  end

  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_busy && frm_cnt != LAST_POS) |=> kick_busy);

  a_r5_clear_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_busy && frm_cnt == LAST_POS) |=> !kick_busy);

  a_r4_rise_needs_kick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kick_busy) |-> $past(kick_wr && kick_wbit));

  a_r3_mult_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_cnt != LAST_POS) |=> $stable(act_mult));

  a_r6_frame_count: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_cnt == LAST_POS) |-> ((fcnt_q + {{STEP_W{1'b0}}, fast_en}) == act_mult));

  a_r9_slow_subset: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |-> fast_en);

  a_r10_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    kick_busy |-> (age_q < (STEP_W+1)'(STEPS)));
endmodule

bind frac_clk_scaler frac_clk_scaler_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .kick_wr(kick_wr), .kick_wbit(kick_wbit),
  .kick_busy(kick_busy), .fast_en(fast_en), .slow_en(slow_en),
  .frm_cnt(frm_cnt), .act_mult(act_mult)
);

// File: tb/frac_clk_scaler_tb.sv
module frac_clk_scaler_tb;
  localparam int PD  = 3;
  localparam int LSB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_wr = 1'b0;
  logic [31:0] rate_wdata = '0;
  logic        kick_wr = 1'b0;
  logic        kick_wbit = 1'b0;
  logic [31:0] rate_rdata;
  logic        kick_busy, fast_en, slow_en;

  int checks = 0;
  int fails  = 0;
  int pcount = 0;
  bit done   = 1'b0;

  always #5ns clk = ~clk;

  frac_clk_scaler #(.STEP_W(5), .FIELD_LSB(LSB), .POST_DIV(PD)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .kick_wr(kick_wr), .kick_wbit(kick_wbit), .rate_rdata(rate_rdata),
    .kick_busy(kick_busy), .fast_en(fast_en), .slow_en(slow_en)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick_and_wait(output int n);
    kick_wr = 1'b1; kick_wbit = 1'b1;
    @(negedge clk);
    kick_wr = 1'b0; kick_wbit = 1'b0;
    n = 0;
    while (kick_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic write_rate(input logic [31:0] w);
    rate_wr = 1'b1; rate_wdata = w;
    @(negedge clk);
    rate_wr = 1'b0;
    check(rate_rdata == w, "R2 readback", rate_rdata, w);
  endtask

  task automatic commit(input int field);
    int n;
    logic [31:0] w;
    w = 32'hA5A5_A0A5 & ~(32'h1F << LSB);
    w = w | (32'(field) << LSB);
    write_rate(w);
    kick_and_wait(n);
    check(n >= 1 && n <= 32, "R10 busy length", n, 32);
    pcount = 0;
  endtask

  task automatic check_frame(input int m, input string tag);
    int cnt = 0, badf = 0, bads = 0, pos_f = -1, pos_s = -1;
    for (int i = 0; i < 32; i++) begin
      bit ef, es;
      ef = (((i + 1) * m) / 32) != ((i * m) / 32);
      es = ef && (((pcount + 1) % PD) == 0);
      if (fast_en !== ef) begin badf++; if (pos_f < 0) pos_f = i; end
      if (slow_en !== es) begin bads++; if (pos_s < 0) pos_s = i; end
      if (fast_en) cnt++;
      if (ef) pcount++;
      @(negedge clk);
    end
    check(cnt == m, {tag, " R6 pulses per frame"}, cnt, m);
    check(badf == 0, {tag, " R7 pulse position mismatch at"}, pos_f, -1);
    check(bads == 0, {tag, " R9 slow strobe mismatch at"}, pos_s, -1);
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(kick_busy == 1'b0, "R1 busy after reset", kick_busy, 0);
    check(rate_rdata == 32'd0, "R1 rate after reset", rate_rdata, 0);
    begin
      int ones = 0;
      for (int i = 0; i < 8; i++) begin ones += fast_en; @(negedge clk); end
      check(ones == 8, "R1 full-rate after reset", ones, 8);
    end

    // R6 R7 R8 R9: all field values
    for (int f = 0; f < 32; f++) begin
      commit(f);
      check_frame(32 - f, (f == 0) ? "R8 field0" : "sweep");
    end

    // R3: rate write without commit keeps cadence
    commit(5);
    check_frame(27, "R3 before");
    write_rate(32'(20) << LSB);
    repeat (31) @(negedge clk);
    check_frame(27, "R3 no commit");

    // R4: commit write with bit clear is ignored
    kick_wr = 1'b1; kick_wbit = 1'b0;
    @(negedge clk);
    kick_wr = 1'b0;
    check(kick_busy == 1'b0, "R4 clear bit no busy", kick_busy, 0);
    repeat (31) @(negedge clk);
    check_frame(27, "R4 ignored");

    // R5: commit in last frame cycle waits a full frame
    commit(12);
    check_frame(20, "R5 base");
    repeat (31) @(negedge clk);
    write_rate(32'(24) << LSB);
    // write_rate consumed one cycle; now at position 0 of the next frame
    repeat (31) @(negedge clk);
    kick_and_wait(n);
    check(n == 32, "R5 late commit busy cycles", n, 32);
    pcount = 0;
    check_frame(8, "R5 after late");

    // R5: commit one cycle before last is taken at this frame end
    repeat (30) @(negedge clk);
    rate_wr = 1'b1; rate_wdata = 32'(31) << LSB;
    @(negedge clk);
    rate_wr = 1'b0;
    // at position 31 now; go round to position 30 of next frame
    repeat (31) @(negedge clk);
    kick_and_wait(n);
    check(n == 1, "R5 early commit busy cycles", n, 1);
    pcount = 0;
    check_frame(1, "R5 after early");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule